// File: doc/BRIEF.md
# Per-Channel Gain Table Controller

This block stores one amplifier gain code for each input of a multiplexed analog input card and drives the right code onto the amplifier's gain-select lines while each channel is converted. Software reaches it through a single byte-wide register. The register's upper two bits hold a gain code, bit 5 holds a table-program flag, and the low five bits hold a channel index.

A register write with the program flag clear selects a channel for conversion. The selected index appears on `sel_chan` for the sequencer, and `conv_req` pulses for one cycle. A register write with the program flag set instead stores the gain code in the table entry addressed by the index. It leaves the selected channel alone and starts no conversion. The sequencer reports the channel it is converting on `act_chan`, and the block returns that channel's stored code on `gain_sel` in the same cycle. Reset does not touch the table, so a table loaded once stays valid for the whole run.

Top module: `gain_table_ctrl`

## Requirements
- R1: After reset, `sel_chan` is 0, `conv_req` is 0, and `reg_rdata[5:0]` reads 0: table-program flag clear, index 0.
- R2: A write with `reg_wdata[5]`=1 stores `reg_wdata[7:6]` into table entry `reg_wdata[4:0]`. Codes 00, 01, 10 and 11 stand for gains 1, 2, 3 and 4 and are stored unchanged.
- R3: A write with `reg_wdata[5]`=1 leaves `sel_chan` unchanged and does not raise `conv_req`.
- R4: A write with `reg_wdata[5]`=0 loads `reg_wdata[4:0]` into `sel_chan` at the write edge and raises `conv_req` for exactly the following cycle. Bits 7:6 of that write are ignored, and the table is unchanged.
- R5: When the last accepted write had bit 5 clear, `reg_rdata` reads `{table[sel_chan], 1'b0, sel_chan}`.
- R6: When the last accepted write had bit 5 set, `reg_rdata` reads `{table[a], 1'b1, a}`, where `a` is the index of that write.
- R7: `gain_sel` equals the stored code of the entry addressed by `act_chan`, in the same cycle that `act_chan` changes.
- R8: Reset clears neither the table nor its effect on `gain_sel` and `reg_rdata`. Entries written before reset read back unchanged after it.
- R9: A program write to the entry that `act_chan` addresses changes `gain_sel` in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one write per cycle it is high |
| reg_wdata | input | 8 | Write byte: [7:6] gain code, [5] program flag, [4:0] channel index |
| reg_rdata | output | 8 | Read-back byte: [7:6] stored code, [5] flag, [4:0] index |
| sel_chan | output | 5 | Channel chosen for conversion, to the sequencer |
| conv_req | output | 1 | One-cycle conversion request after a channel-select write |
| act_chan | input | 5 | Channel the sequencer is converting now |
| gain_sel | output | 2 | Gain code to the amplifier for `act_chan` |

## Verification
The hardest case to reach is a table write that lands on the very entry being converted, because it has to show up on `gain_sel` one cycle later without any change to `act_chan`. The stimulus reaches it on purpose: it parks `act_chan` on a channel, then reprograms that entry with a different code. The random phase also lets the program index and `act_chan` collide. A reset in the middle of the run, with the table fully loaded, shows that stored entries survive while the selection registers return to zero.

// File: rtl/gtc_pkg.sv
`timescale 1ns/1ps
package gtc_pkg;
  // Meaning of the flag bit in the register byte.
  typedef enum logic {
    MODE_SELECT  = 1'b0,
    MODE_PROGRAM = 1'b1
  } tbl_mode_e;

  localparam int DEF_CHAN_W = 5;
  localparam int DEF_GAIN_W = 2;
endpackage

// File: rtl/gtc_rst_sync.sv
`timescale 1ns/1ps
module gtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/gtc_wr_decode.sv
`timescale 1ns/1ps
module gtc_wr_decode
  import gtc_pkg::*;
#(
  parameter int CHAN_W = DEF_CHAN_W,
  parameter int GAIN_W = DEF_GAIN_W,
  localparam int REG_W = GAIN_W + 1 + CHAN_W
) (
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic              tbl_we,
  output logic              sel_we,
  output logic [CHAN_W-1:0] idx,
  output logic [GAIN_W-1:0] code
);
  tbl_mode_e mode;

  always_comb begin
    mode   = tbl_mode_e'(wdata[CHAN_W]);
    idx    = wdata[CHAN_W-1:0];
    code   = wdata[REG_W-1 -: GAIN_W];
    tbl_we = wr && (mode == MODE_PROGRAM);
    sel_we = wr && (mode == MODE_SELECT);
  end
endmodule

// File: rtl/gtc_gain_ram.sv
`timescale 1ns/1ps
module gtc_gain_ram
  import gtc_pkg::*;
#(
  parameter int CHAN_W = DEF_CHAN_W,
  parameter int GAIN_W = DEF_GAIN_W,
  localparam int NUM_CHAN = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CHAN_W-1:0] waddr,
  input  logic [GAIN_W-1:0] wdata,
  input  logic [CHAN_W-1:0] conv_addr,
  output logic [GAIN_W-1:0] conv_code,
  input  logic [CHAN_W-1:0] rb_addr,
  output logic [GAIN_W-1:0] rb_code
);
  logic [GAIN_W-1:0] mem_q [NUM_CHAN];
  logic [NUM_CHAN-1:0] ent_en;

  // One clock enable per entry.
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_ent
    assign ent_en[i] = we && (waddr == CHAN_W'(i));
  end

  // Table contents carry no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (ent_en[i]) mem_q[i] <= wdata;
    end
  end

  assign conv_code = mem_q[conv_addr];
  assign rb_code   = mem_q[rb_addr];
endmodule

// File: rtl/gtc_chan_reg.sv
`timescale 1ns/1ps
module gtc_chan_reg
  import gtc_pkg::*;
#(
  parameter int CHAN_W = DEF_CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic              tbl_we,
  input  logic [CHAN_W-1:0] idx,
  output logic [CHAN_W-1:0] sel_chan,
  output logic [CHAN_W-1:0] prog_addr,
  output tbl_mode_e         mode,
  output logic              conv_req
);
  logic [CHAN_W-1:0] sel_q, sel_d;
  logic [CHAN_W-1:0] paddr_q, paddr_d;
  tbl_mode_e         mode_q, mode_d;
  logic              conv_q, conv_d;

  always_comb begin
    sel_d   = sel_q;
    paddr_d = paddr_q;
    mode_d  = mode_q;
    conv_d  = 1'b0;
    if (sel_we) begin
      sel_d  = idx;
      mode_d = MODE_SELECT;
      conv_d = 1'b1;
    end
    if (tbl_we) begin
      paddr_d = idx;
      mode_d  = MODE_PROGRAM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      paddr_q <= '0;
      mode_q  <= MODE_SELECT;
      conv_q  <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      paddr_q <= paddr_d;
      mode_q  <= mode_d;
      conv_q  <= conv_d;
    end
  end

  assign sel_chan  = sel_q;
  assign prog_addr = paddr_q;
  assign mode      = mode_q;
  assign conv_req  = conv_q;

  // R3
  prog_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> $stable(sel_chan));

  // R3
  prog_no_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> !conv_req);

  // R4
  sel_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (conv_req && sel_chan == $past(idx)));

  // R4
  conv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(sel_we));
endmodule

// File: rtl/gain_table_ctrl.sv
`timescale 1ns/1ps
module gain_table_ctrl
  import gtc_pkg::*;
#(
  parameter int CHAN_W = DEF_CHAN_W,
  parameter int GAIN_W = DEF_GAIN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [GAIN_W+CHAN_W:0]   reg_wdata,
  output logic [GAIN_W+CHAN_W:0]   reg_rdata,
  output logic [CHAN_W-1:0]        sel_chan,
  output logic                     conv_req,
  input  logic [CHAN_W-1:0]        act_chan,
  output logic [GAIN_W-1:0]        gain_sel
);
  localparam int REG_W = GAIN_W + 1 + CHAN_W;

  logic              rst_s;
  logic              dec_tbl_we, dec_sel_we;
  logic [CHAN_W-1:0] dec_idx;
  logic [GAIN_W-1:0] dec_code;
  logic [CHAN_W-1:0] prog_addr, rb_idx;
  logic [GAIN_W-1:0] rb_code;
  tbl_mode_e         mode;

  gtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  gtc_wr_decode #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) u_dec (
    .wr(reg_wr), .wdata(reg_wdata), .tbl_we(dec_tbl_we),
    .sel_we(dec_sel_we), .idx(dec_idx), .code(dec_code)
  );

  gtc_chan_reg #(.CHAN_W(CHAN_W)) u_chan (
    .clk(clk), .rst_n(rst_s), .sel_we(dec_sel_we), .tbl_we(dec_tbl_we),
    .idx(dec_idx), .sel_chan(sel_chan), .prog_addr(prog_addr),
    .mode(mode), .conv_req(conv_req)
  );

  always_comb begin
    rb_idx = (mode == MODE_PROGRAM) ? prog_addr : sel_chan;
  end

  gtc_gain_ram #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) u_ram (
    .clk(clk), .we(dec_tbl_we), .waddr(dec_idx), .wdata(dec_code),
    .conv_addr(act_chan), .conv_code(gain_sel),
    .rb_addr(rb_idx), .rb_code(rb_code)
  );

  assign reg_rdata = {rb_code, mode, rb_idx};

  // R2
  prog_readback_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dec_tbl_we |=> (reg_rdata[REG_W-1 -: GAIN_W] == $past(dec_code)
                    && reg_rdata[CHAN_W-1:0] == $past(dec_idx)));

  // R9
  live_update_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (dec_tbl_we && dec_idx == act_chan) |=>
      (!$stable(act_chan) || gain_sel == $past(dec_code)));
endmodule

// File: tb/gain_table_ctrl_tb.sv
`timescale 1ns/1ps
module gain_table_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [4:0] sel_chan;
  logic       conv_req;
  logic [4:0] act_chan;
  logic [1:0] gain_sel;

  always #2 clk = ~clk;

  gain_table_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sel_chan(sel_chan), .conv_req(conv_req),
    .act_chan(act_chan), .gain_sel(gain_sel)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] m_tbl [32];
  logic [4:0] m_sel;
  logic       m_prog;
  logic [4:0] m_paddr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    logic [4:0] a;
    a = m_prog ? m_paddr : m_sel;
    return {m_tbl[a], m_prog, a};
  endfunction

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (d[5]) begin
      m_tbl[d[4:0]] = d[7:6];
      m_paddr = d[4:0];
      m_prog = 1'b1;
    end else begin
      m_sel = d[4:0];
      m_prog = 1'b0;
    end
    chk(conv_req == !d[5], d[5] ? "R3 no conv on program write" : "R4 conv pulse",
        int'(conv_req), int'(!d[5]));
    chk(sel_chan == m_sel, d[5] ? "R3 sel kept" : "R4 sel loaded",
        int'(sel_chan), int'(m_sel));
    chk(reg_rdata == exp_rd(), d[5] ? "R6 readback program" : "R5 readback select",
        int'(reg_rdata), int'(exp_rd()));
    chk(gain_sel == m_tbl[act_chan], "R9 gain_sel after write",
        int'(gain_sel), int'(m_tbl[act_chan]));
    @(negedge clk);
    chk(conv_req == 1'b0, "R4 conv one cycle", int'(conv_req), 0);
  endtask

  task automatic set_act(input logic [4:0] c);
    @(negedge clk);
    act_chan = c;
    #1;
    chk(gain_sel == m_tbl[c], "R7 gain for act_chan", int'(gain_sel), int'(m_tbl[c]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_sel = '0;
    m_prog = 1'b0;
    m_paddr = '0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [4:0] c;
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = '0;
    act_chan = '0;
    do_reset();
    // R1 reset state
    chk(sel_chan == 5'd0, "R1 sel_chan reset", int'(sel_chan), 0);
    chk(conv_req == 1'b0, "R1 conv_req reset", int'(conv_req), 0);
    chk(reg_rdata[5:0] == 6'd0, "R1 rdata reset", int'(reg_rdata[5:0]), 0);

    // R2 load every entry
    for (int i = 0; i < 32; i++) do_write({2'(i * 3 + 1), 1'b1, 5'(i)});
    for (int i = 0; i < 32; i++) set_act(5'(i));

    // Boundary indices and all codes
    do_write({2'b11, 1'b1, 5'd31});
    do_write({2'b00, 1'b1, 5'd0});
    set_act(5'd31);
    set_act(5'd0);

    // R4 gain bits of a select write are ignored
    do_write({~m_tbl[7], 1'b0, 5'd7});
    chk(reg_rdata[7:6] == m_tbl[7], "R4 table unchanged by select",
        int'(reg_rdata[7:6]), int'(m_tbl[7]));

    // R9 reprogram the entry being converted
    set_act(5'd12);
    do_write({~m_tbl[12], 1'b1, 5'd12});
    chk(gain_sel == m_tbl[12], "R9 live entry update", int'(gain_sel), int'(m_tbl[12]));

    // Random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(2) == 0) set_act(5'($urandom_range(31)));
      else do_write(8'($urandom));
    end

    // R8 table survives reset
    do_reset();
    chk(sel_chan == 5'd0, "R1 sel_chan after reset", int'(sel_chan), 0);
    chk(reg_rdata == exp_rd(), "R8 readback after reset",
        int'(reg_rdata), int'(exp_rd()));
    for (int i = 0; i < 32; i++) begin
      c = 5'(i);
      @(negedge clk);
      act_chan = c;
      #1;
      chk(gain_sel == m_tbl[c], "R8 entry kept through reset",
          int'(gain_sel), int'(m_tbl[c]));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule